// File: doc/BRIEF.md
# Protected Translation-Table Invalidation Controller

This block owns two small translation tables (table 0 and table 1) and removes entries from them on command. A command is either an invalidate, which carries an address whose low bits choose the table and whether one page or the whole table is affected, or a flush, which carries type bits naming one or both tables. After a command is accepted, the controller steps through the entry indices, one per cycle, and clears the valid bit of every entry that the command selects. Entries marked as protected survive every operation except a whole-table invalidate of table 0.

Each entry holds a page number in 1 KB units, a size code, a valid bit and a protect bit. A simple load port fills entries while the controller is idle, and a read port returns the valid bit of any entry so that the result of a command can be observed. A one-cycle done pulse marks the end of every command.

Top module: `tlbi_ctrl`

## Requirements
- R1: After reset every entry of both tables is invalid, and busy_o and done_o are low.
- R2: While busy_o is low, a cycle with ld_en_i high writes page number, size code, valid and protect into entry ld_idx_i of the table chosen by ld_tbl_i (0 = table 0, 1 = table 1); while busy_o is high ld_en_i has no effect.
- R3: A command is taken on a clock edge where cmd_valid_i is high and busy_o is low; busy_o is then high for exactly NUM_ENTRIES cycles, one entry index per cycle, and commands offered while busy_o is high are dropped.
- R4: done_o is high for exactly one cycle, the cycle right after busy_o falls, NUM_ENTRIES+1 cycles after the accepting edge's following cycle begins counting at 1.
- R5: For an invalidate (cmd_flush_i = 0), cmd_addr_i bit 3 picks the table (1 = table 1, 0 = table 0) and cmd_addr_i bit 2 set means the whole table rather than one page.
- R6: A single-page invalidate clears a valid entry only when its page number equals cmd_addr_i[31:10] with its low 2*size bits forced to zero (page size 1 KB times 4 to the power of the size code) and its protect bit is clear.
- R7: A whole-table invalidate of table 0 clears every entry of table 0, protected or not.
- R8: A whole-table invalidate of table 1 clears every unprotected entry of table 1 and leaves protected ones valid.
- R9: For a flush (cmd_flush_i = 1), cmd_type_i bit 1 selects table 1 and bit 2 selects table 0, both may be set, and every unprotected entry of each selected table is cleared while protected entries stay valid.
- R10: A flush with cmd_type_i bits 1 and 2 both clear still produces a done pulse and changes no entry.
- R11: Entries of the table that a command does not select, and entries that do not match a single-page invalidate, keep their valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_flush_i | input | 1 | 1 = flush command, 0 = invalidate command |
| cmd_addr_i | input | ADDR_W | Invalidate address; bits 3:2 carry table and scope |
| cmd_type_i | input | 3 | Flush type; bit 1 = table 1, bit 2 = table 0 |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ld_en_i | input | 1 | Load an entry |
| ld_tbl_i | input | 1 | Table to load |
| ld_idx_i | input | IDX_W | Entry index to load |
| ld_epn_i | input | ADDR_W-10 | Page number in 1 KB units |
| ld_size_i | input | SIZE_W | Page size code |
| ld_valid_i | input | 1 | Valid bit to load |
| ld_prot_i | input | 1 | Protect bit to load |
| rd_tbl_i | input | 1 | Table to read |
| rd_idx_i | input | IDX_W | Entry index to read |
| rd_valid_o | output | 1 | Valid bit of the addressed entry |

## Verification
On every cycle the assertions check that a protected valid entry of table 1 is never lost, that no valid bit changes while the controller is idle without a load, that a walk never sets a valid bit, and that each done pulse is single and ends a walk of exactly NUM_ENTRIES cycles. Which entries a given command clears, the page-size masking of single-page matches, the table-0 whole-table override of protection, and the dropping of commands and loads offered mid-walk can only be shown by the bench's scenarios, which compare every entry of both tables against an arithmetic model after each command.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;

  typedef struct packed {
    logic sel0;   // table 0 targeted
    logic sel1;   // table 1 targeted
    logic whole;  // whole table, not one page
    logic honor;  // protect bits respected
  } tlbi_op_t;

  typedef enum logic {
    ST_IDLE,
    ST_WALK
  } walk_st_e;

endpackage

// File: rtl/tlbi_decode.sv
module tlbi_decode (
  input  logic               flush_i,
  input  logic [3:2]         addr_lo_i,
  input  logic [2:1]         type_i,
  output tlbi_pkg::tlbi_op_t op_o
);

  always_comb begin
    if (flush_i) begin
      op_o.sel1  = type_i[1];
      op_o.sel0  = type_i[2];
      op_o.whole = 1'b1;
      op_o.honor = 1'b1;
    end else begin
      op_o.sel1  = addr_lo_i[3];
      op_o.sel0  = ~addr_lo_i[3];
      op_o.whole = addr_lo_i[2];
      // only a whole-table sweep of table 0 overrides protection
      op_o.honor = ~(addr_lo_i[2] & ~addr_lo_i[3]);
    end
  end

endmodule

// File: rtl/tlbi_walk.sv
module tlbi_walk #(
  parameter int NUM_ENTRIES = 8,
  parameter int EPN_W       = 22,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  tlbi_pkg::tlbi_op_t op_i,
  input  logic [EPN_W-1:0]   epn_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [IDX_W-1:0]   idx_o,
  output tlbi_pkg::tlbi_op_t op_o,
  output logic [EPN_W-1:0]   epn_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  tlbi_pkg::walk_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= tlbi_pkg::ST_IDLE;
      idx_o  <= '0;
      done_o <= 1'b0;
      op_o   <= '0;
      epn_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        tlbi_pkg::ST_IDLE: begin
          if (start_i) begin
            st_q  <= tlbi_pkg::ST_WALK;
            idx_o <= '0;
            op_o  <= op_i;
            epn_o <= epn_i;
          end
        end
        default: begin
          if (idx_o == LAST_IDX) begin
            st_q   <= tlbi_pkg::ST_IDLE;
            done_o <= 1'b1;
          end else begin
            idx_o <= idx_o + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o = (st_q == tlbi_pkg::ST_WALK);

endmodule

// File: rtl/tlbi_table.sv
module tlbi_table #(
  parameter int NUM_ENTRIES = 8,
  parameter int EPN_W       = 22,
  parameter int SIZE_W      = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ld_en_i,
  input  logic [IDX_W-1:0]       ld_idx_i,
  input  logic [EPN_W-1:0]       ld_epn_i,
  input  logic [SIZE_W-1:0]      ld_size_i,
  input  logic                   ld_valid_i,
  input  logic                   ld_prot_i,
  input  logic                   walk_en_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic                   whole_i,
  input  logic                   honor_i,
  input  logic [EPN_W-1:0]       epn_i,
  input  logic [IDX_W-1:0]       rd_idx_i,
  output logic                   rd_valid_o,
  output logic [NUM_ENTRIES-1:0] valid_o,
  output logic [NUM_ENTRIES-1:0] prot_o
);

  logic [EPN_W-1:0]  epn_q  [NUM_ENTRIES];
  logic [SIZE_W-1:0] size_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] valid_q, prot_q;

  logic [EPN_W-1:0] cur_mask;
  logic             epn_hit, clr;

  always_comb begin
    cur_mask = {EPN_W{1'b1}} << (2 * int'(size_q[idx_i]));
    epn_hit  = (epn_q[idx_i] == (epn_i & cur_mask));
    clr      = walk_en_i & valid_q[idx_i] & (whole_i | epn_hit) &
               (~honor_i | ~prot_q[idx_i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      prot_q  <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        epn_q[e]  <= '0;
        size_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (ld_en_i && ld_idx_i == IDX_W'(e)) begin
          epn_q[e]   <= ld_epn_i;
          size_q[e]  <= ld_size_i;
          valid_q[e] <= ld_valid_i;
          prot_q[e]  <= ld_prot_i;
        end else if (clr && idx_i == IDX_W'(e)) begin
          valid_q[e] <= 1'b0;
        end
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign valid_o    = valid_q;
  assign prot_o     = prot_q;

endmodule

// File: rtl/tlbi_ctrl.sv
module tlbi_ctrl #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_flush_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [2:0]        cmd_type_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              ld_en_i,
  input  logic              ld_tbl_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [ADDR_W-11:0] ld_epn_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  input  logic              ld_valid_i,
  input  logic              ld_prot_i,
  input  logic              rd_tbl_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o
);

  localparam int EPN_W = ADDR_W - 10;

  tlbi_pkg::tlbi_op_t dec_op, walk_op;
  logic [EPN_W-1:0]   walk_epn;
  logic [IDX_W-1:0]   walk_idx;
  logic               walk_busy;

  logic [NUM_ENTRIES-1:0] tbl_valid [2];
  logic [NUM_ENTRIES-1:0] tbl_prot  [2];
  logic [1:0]             tbl_rd;
  logic [1:0]             tbl_sel;

  logic [NUM_ENTRIES-1:0] t0_valid, t1_valid, t1_prot;
  logic                   unused_bits;

  assign unused_bits = ^{cmd_addr_i[9:4], cmd_addr_i[1:0], cmd_type_i[0], tbl_prot[0]};

  tlbi_decode u_dec (
    .flush_i   (cmd_flush_i),
    .addr_lo_i (cmd_addr_i[3:2]),
    .type_i    (cmd_type_i[2:1]),
    .op_o      (dec_op)
  );

  tlbi_walk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .EPN_W       (EPN_W)
  ) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_valid_i),
    .op_i    (dec_op),
    .epn_i   (cmd_addr_i[ADDR_W-1:10]),
    .busy_o  (walk_busy),
    .done_o  (done_o),
    .idx_o   (walk_idx),
    .op_o    (walk_op),
    .epn_o   (walk_epn)
  );

  assign tbl_sel = {walk_op.sel1, walk_op.sel0};

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    tlbi_table #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .EPN_W       (EPN_W),
      .SIZE_W      (SIZE_W)
    ) u_tbl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ld_en_i    (ld_en_i & ~walk_busy & (ld_tbl_i == 1'(t))),
      .ld_idx_i   (ld_idx_i),
      .ld_epn_i   (ld_epn_i),
      .ld_size_i  (ld_size_i),
      .ld_valid_i (ld_valid_i),
      .ld_prot_i  (ld_prot_i),
      .walk_en_i  (walk_busy & tbl_sel[t]),
      .idx_i      (walk_idx),
      .whole_i    (walk_op.whole),
      .honor_i    (walk_op.honor),
      .epn_i      (walk_epn),
      .rd_idx_i   (rd_idx_i),
      .rd_valid_o (tbl_rd[t]),
      .valid_o    (tbl_valid[t]),
      .prot_o     (tbl_prot[t])
    );
  end

  assign busy_o     = walk_busy;
  assign rd_valid_o = tbl_rd[rd_tbl_i];
  assign t0_valid   = tbl_valid[0];
  assign t1_valid   = tbl_valid[1];
  assign t1_prot    = tbl_prot[1];

endmodule

// File: rtl/tlbi_ctrl_chk.sv
module tlbi_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         busy_i,
  input logic         done_i,
  input logic         ld_en_i,
  input logic [N-1:0] t0_valid_i,
  input logic [N-1:0] t1_valid_i,
  input logic [N-1:0] t1_prot_i
);

  logic [$clog2(N+1):0] walk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      walk_cnt <= '0;
    else if (!busy_i) walk_cnt <= '0;
    else              walk_cnt <= walk_cnt + 1'b1;
  end

  AST_DONE_ENDS_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!busy_i && $past(busy_i)));  // R4

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);  // R4

  AST_WALK_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (walk_cnt == ($bits(walk_cnt))'(N)));  // R3

  AST_T1_PROT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_en_i |=> ((($past(t1_valid_i) & $past(t1_prot_i)) & ~t1_valid_i) == '0));  // R8

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !ld_en_i) |=> (t0_valid_i == $past(t0_valid_i) &&
                               t1_valid_i == $past(t1_valid_i)));  // R11

  AST_WALK_NEVER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (((t0_valid_i & ~$past(t0_valid_i)) == '0) &&
                ((t1_valid_i & ~$past(t1_valid_i)) == '0)));  // R2

endmodule

bind tlbi_ctrl tlbi_ctrl_chk #(.N(NUM_ENTRIES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .ld_en_i    (ld_en_i),
  .t0_valid_i (t0_valid),
  .t1_valid_i (t1_valid),
  .t1_prot_i  (t1_prot)
);

// File: tb/tlbi_ctrl_test.sv
module tlbi_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int AW         = 32;
  localparam int SW         = 4;
  localparam int IW         = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0, cmd_flush_i = 1'b0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [2:0] cmd_type_i = '0;
  logic busy_o, done_o;
  logic ld_en_i = 1'b0, ld_tbl_i = 1'b0, ld_valid_i = 1'b0, ld_prot_i = 1'b0;
  logic [IW-1:0] ld_idx_i = '0;
  logic [AW-11:0] ld_epn_i = '0;
  logic [SW-1:0] ld_size_i = '0;
  logic rd_tbl_i = 1'b0;
  logic [IW-1:0] rd_idx_i = '0;
  logic rd_valid_o;

  int checks = 0;
  int errors = 0;

  logic        m_v [2][N];
  logic        m_p [2][N];
  int unsigned m_e [2][N];
  int unsigned m_s [2][N];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tlbi_ctrl #(.NUM_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW)) uut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(int t, int i, int unsigned epn, int unsigned sz, logic v, logic p);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_tbl_i = t[0]; ld_idx_i = IW'(i);
    ld_epn_i = (AW-10)'(epn); ld_size_i = SW'(sz); ld_valid_i = v; ld_prot_i = p;
    @(negedge clk_i);
    ld_en_i = 1'b0;
    m_v[t][i] = v; m_p[t][i] = p; m_e[t][i] = epn; m_s[t][i] = sz;
  endtask

  // pattern: pairs share a page number with different size codes
  task automatic load_all();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++)
        load(t, i, (((i >> 1) + 1) + 8 * t) << 6, i % 4, (i != 5), (i % 3 == 0));
  endtask

  task automatic verify(string req);
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++) begin
        rd_tbl_i = t[0]; rd_idx_i = IW'(i);
        #1;
        chk(req, $sformatf("tbl%0d entry%0d valid", t, i), int'(rd_valid_o), int'(m_v[t][i]));
      end
  endtask

  // expected effect of a command, derived from R5..R11
  task automatic model(logic fl, logic [AW-1:0] a, logic [2:0] ty);
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++) begin
        logic sel, whole, honor, match;
        int unsigned mask;
        sel   = fl ? (t == 1 ? ty[1] : ty[2]) : (a[3] == t[0]);
        whole = fl ? 1'b1 : a[2];
        honor = fl ? 1'b1 : !(a[2] && !a[3]);
        mask  = ~((32'd1 << (2 * m_s[t][i])) - 1);
        match = whole || (m_e[t][i] == ((a >> 10) & mask));
        if (m_v[t][i] && sel && match && !(honor && m_p[t][i])) m_v[t][i] = 1'b0;
      end
  endtask

  task automatic run_cmd(string req, logic fl, logic [AW-1:0] a, logic [2:0] ty);
    int cnt;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_flush_i = fl; cmd_addr_i = a; cmd_type_i = ty;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk("R3", "busy after accept", int'(busy_o), 1);
    cnt = 1;
    while (!done_o && cnt < 50) begin
      @(negedge clk_i);
      cnt++;
    end
    chk("R4", "cycles to done", cnt, N + 1);
    chk("R3", "busy at done", int'(busy_o), 0);
    @(negedge clk_i);
    chk("R4", "done single pulse", int'(done_o), 0);
    model(fl, a, ty);
    verify(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++) begin
        m_v[t][i] = 1'b0; m_p[t][i] = 1'b0; m_e[t][i] = 0; m_s[t][i] = 0;
      end
    repeat (3) @(negedge clk_i);
    chk("R1", "busy in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "busy after reset", int'(busy_o), 0);
    chk("R1", "done after reset", int'(done_o), 0);
    verify("R1");

    load_all();
    verify("R2");

    // R6: single-page sweep, every entry as target, offset inside its page
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++) begin
        int unsigned pg, a;
        load_all();
        pg = 32'd1024 << (2 * (i % 4));
        a  = (m_e[t][i] << 10) | (((pg >> 1) | 32'h0F0) & ~32'hC) | (t << 3);
        run_cmd("R6", 1'b0, a, 3'b000);
      end

    // R11: page miss in each table
    load_all();
    run_cmd("R11", 1'b0, 32'h0FFF_0000, 3'b000);
    run_cmd("R11", 1'b0, 32'h0FFF_0008, 3'b000);

    // R5/R7: whole table 0 ignores protection; R8: whole table 1 honours it
    load_all();
    run_cmd("R7", 1'b0, 32'h0000_0004, 3'b000);
    load_all();
    run_cmd("R8", 1'b0, 32'h0000_000C, 3'b000);
    load_all();
    run_cmd("R5", 1'b0, 32'h0000_4000 | 32'h8, 3'b000);

    // R9: flush types
    load_all();
    run_cmd("R9", 1'b1, 32'h0, 3'b010);
    load_all();
    run_cmd("R9", 1'b1, 32'h0, 3'b100);
    load_all();
    run_cmd("R9", 1'b1, 32'h0, 3'b111);

    // R10: no table bits
    load_all();
    run_cmd("R10", 1'b1, 32'hFFFF_FFFF, 3'b001);

    // R3/R2: command and load offered mid-walk are dropped
    load_all();
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_flush_i = 1'b1; cmd_type_i = 3'b110; cmd_addr_i = '0;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_flush_i = 1'b0; cmd_addr_i = 32'h4;
    ld_en_i = 1'b1; ld_tbl_i = 1'b0; ld_idx_i = 3'd5; ld_valid_i = 1'b1;
    ld_prot_i = 1'b1; ld_epn_i = '0; ld_size_i = '0;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; ld_en_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
    chk("R3", "busy after dropped command", int'(busy_o), 0);
    model(1'b1, '0, 3'b110);
    verify("R3");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule